// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a single-data-rate synchronous memory with one shared data port, modelled at the block edge as an input bus, an output bus and an output enable. All command inputs are captured on the rising clock edge. A read returns its data, registered, on the edge after the command edge. A write takes its data and byte enables on the edge after the command edge. That data then sits in a two-entry write buffer before it reaches the storage array. Reads check the buffer so that they always return the newest value of every byte.

A command may start a short burst. Later cycles with the advance input high step the address through the low two bits, wrapping inside the aligned group of four words. Several instances can share one bus as banks. Each instance compares its bank-enable inputs against its polarity-programming inputs and responds only when they match.

Top module: `lw_sram`

## Requirements
- R1: While reset is high and after it is released, `dq_oe` and `dq_out` are 0, the write buffer is empty and every array word reads as 0.
- R2: A new access starts at a rising edge where `adv`=0, `cs`=1 and `bank_ce` equals `bank_pol` bit for bit. `we`=1 selects a write and `we`=0 a read.
- R3: The data of a read started at edge N is on `dq_out`, with `dq_oe`=1, from edge N+1 until edge N+2.
- R4: For a write started at edge N, `dq_in` and `bwe` are sampled at edge N+1.
- R5: Byte lane i is bits [9i+8:9i]. On a write beat, only lanes whose `bwe` bit is 1 change. The other lanes keep their earlier value.
- R6: A read returns, for each byte, the value written most recently, including writes still held in the write buffer. This holds even when the write data arrived at the same edge that sampled the read command.
- R7: The write buffer holds at most two writes. It retires its oldest entry on any edge without a new write. When it is full and a write arrives, the oldest entry is stored in the same edge.
- R8: `blen` gives the burst length as `blen`+1 beats (1 to 4). Each following `adv`=1 cycle accesses the next address: the low two bits increment modulo 4 and the upper bits stay fixed. Every beat keeps the direction of the first beat.
- R9: `adv`=1 when no beats of a burst are left, whether no burst was started or its last beat has passed, performs no access. No read data is driven and nothing is written.
- R10: A command with `bank_ce` different from `bank_pol`, or with `cs`=0, performs no access. It has no effect on stored data or on `dq_oe`.
- R11: `dq_oe` is 0 in every cycle that does not carry read data, including write data cycles and deselect cycles.
- R12: An edge with `adv`=0 ends any burst in progress. That edge then either starts a new access or deselects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Select for a new command |
| we | input | 1 | 1 = write, 0 = read, for a new command |
| adv | input | 1 | Continue the current burst instead of starting a command |
| blen | input | 2 | Burst length minus one |
| addr | input | ADDR_W | Word address of a new command |
| bank_ce | input | NCE | Bank-enable inputs |
| bank_pol | input | NCE | Programmed polarity that `bank_ce` must match |
| bwe | input | NBYTE | Byte write enables, sampled with the write data |
| dq_in | input | DATA_W | Write data, one edge after the write command |
| dq_out | output | DATA_W | Registered read data |
| dq_oe | output | 1 | High while `dq_out` carries read data |

## Verification
Read data is due one edge after its command edge. The bench therefore drives each row at a falling edge and steps its reference model at the rising edge. It compares `dq_oe` and `dq_out` at the next falling edge against the access the model recorded one row earlier. Write data belongs to the row after its command. The model applies it before it decodes the command of that same row, which covers a read issued in the cycle the write data arrives. Burst beats, stray advances and bank mismatches are checked the same way, one edge after each beat's command.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    localparam int DEF_ADDR_W = 6;
    localparam int DEF_DATA_W = 36;
    localparam int DEF_BYTE_W = 9;
    localparam int DEF_NCE    = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // burst bookkeeping carried from one beat to the next
    typedef struct packed {
        op_e        op;
        logic       wr;
        logic [1:0] left;
    } beat_t;

    // linear step inside an aligned group of four words
    function automatic logic [1:0] step_lo(input logic [1:0] lo);
        return lo + 2'd1;
    endfunction

endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int NCE    = DEF_NCE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              we,
    input  logic              adv,
    input  logic [1:0]        blen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NCE-1:0]    bank_ce,
    input  logic [NCE-1:0]    bank_pol,
    output op_e               acc_op,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              burst_live
);

    beat_t             cur_q, cur_d;
    logic [ADDR_W-1:0] adr_q, adr_d;
    logic              bank_hit;

    assign bank_hit = (bank_ce == bank_pol);

    // R2 R8 R9 R10 R12: command decode and burst stepping
    always_comb begin
        cur_d = '{op: OP_IDLE, wr: cur_q.wr, left: 2'd0};
        adr_d = adr_q;
        if (adv) begin
            if (cur_q.left != 2'd0) begin
                cur_d.op   = cur_q.wr ? OP_WRITE : OP_READ;
                cur_d.left = cur_q.left - 2'd1;
                adr_d      = {adr_q[ADDR_W-1:2], step_lo(adr_q[1:0])};
            end
        end else if (cs && bank_hit) begin
            cur_d.op   = we ? OP_WRITE : OP_READ;
            cur_d.wr   = we;
            cur_d.left = blen;
            adr_d      = addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{op: OP_IDLE, wr: 1'b0, left: 2'd0};
            adr_q <= '0;
        end else begin
            cur_q <= cur_d;
            adr_q <= adr_d;
        end
    end

    assign acc_op     = cur_q.op;
    assign acc_addr   = adr_q;
    assign burst_live = (cur_q.left != 2'd0);

endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int BYTE_W = DEF_BYTE_W,
    localparam int NBYTE = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [NBYTE-1:0]  push_be,
    input  logic [DATA_W-1:0] push_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] base_data,
    output logic [DATA_W-1:0] snoop_data,
    output logic              commit_en,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [NBYTE-1:0]  commit_be,
    output logic [DATA_W-1:0] commit_data,
    output logic [1:0]        fill
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [NBYTE-1:0]  be;
        logic [DATA_W-1:0] data;
    } ent_t;

    ent_t       old_q, new_q, arrive;
    logic       old_v, new_v;
    logic [NBYTE-1:0] hit_old, hit_new;

    assign arrive = '{addr: push_addr, be: push_be, data: push_data};

    // R7: retire the oldest entry on an edge with no arrival, or when full
    assign commit_en   = old_v && (!push || new_v);
    assign commit_addr = old_q.addr;
    assign commit_be   = old_q.be;
    assign commit_data = old_q.data;
    assign fill        = {old_v & new_v, old_v ^ new_v};

    always_ff @(posedge clk) begin
        if (rst) begin
            old_v <= 1'b0;
            new_v <= 1'b0;
            old_q <= '0;
            new_q <= '0;
        end else if (commit_en) begin
            new_v <= 1'b0;
            if (new_v) begin
                old_q <= new_q;
                old_v <= 1'b1;
                if (push) begin
                    new_q <= arrive;
                    new_v <= 1'b1;
                end
            end else begin
                old_v <= 1'b0;
            end
        end else if (push) begin
            if (!old_v) begin
                old_q <= arrive;
                old_v <= 1'b1;
            end else begin
                new_q <= arrive;
                new_v <= 1'b1;
            end
        end
    end

    // R6: per-lane address and enable match against both entries
    for (genvar b = 0; b < NBYTE; b++) begin : g_lane
        assign hit_old[b] = old_v && (old_q.addr == rd_addr) && old_q.be[b];
        assign hit_new[b] = new_v && (new_q.addr == rd_addr) && new_q.be[b];
    end

    always_comb begin
        snoop_data = base_data;
        for (int b = 0; b < NBYTE; b++) begin
            if (hit_new[b])
                snoop_data[b*BYTE_W +: BYTE_W] = new_q.data[b*BYTE_W +: BYTE_W];
            else if (hit_old[b])
                snoop_data[b*BYTE_W +: BYTE_W] = old_q.data[b*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int BYTE_W = DEF_BYTE_W,
    localparam int NBYTE = DATA_W / BYTE_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NBYTE-1:0]  wr_be,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    // R1 clear on reset, R5 byte-masked store
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < NBYTE; b++)
                if (wr_be[b])
                    mem[wr_addr][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int BYTE_W = DEF_BYTE_W,
    parameter int NCE    = DEF_NCE,
    localparam int NBYTE = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              we,
    input  logic              adv,
    input  logic [1:0]        blen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NCE-1:0]    bank_ce,
    input  logic [NCE-1:0]    bank_pol,
    input  logic [NBYTE-1:0]  bwe,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    op_e               acc_op;
    logic [ADDR_W-1:0] acc_addr;
    logic              burst_live;
    logic [DATA_W-1:0] arr_data, rd_merged, cm_data;
    logic              cm_en;
    logic [ADDR_W-1:0] cm_addr;
    logic [NBYTE-1:0]  cm_be;
    logic [1:0]        buf_fill;
    logic              wr_arrive;

    lw_sram_ctrl #(.ADDR_W(ADDR_W), .NCE(NCE)) u_ctrl (
        .clk(clk), .rst(rst), .cs(cs), .we(we), .adv(adv), .blen(blen),
        .addr(addr), .bank_ce(bank_ce), .bank_pol(bank_pol),
        .acc_op(acc_op), .acc_addr(acc_addr), .burst_live(burst_live)
    );

    // R4: the write data for the access held this cycle arrives at the next edge
    assign wr_arrive = (acc_op == OP_WRITE);

    lw_sram_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_wbuf (
        .clk(clk), .rst(rst), .push(wr_arrive), .push_addr(acc_addr),
        .push_be(bwe), .push_data(dq_in), .rd_addr(acc_addr),
        .base_data(arr_data), .snoop_data(rd_merged), .commit_en(cm_en),
        .commit_addr(cm_addr), .commit_be(cm_be), .commit_data(cm_data),
        .fill(buf_fill)
    );

    lw_sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_array (
        .clk(clk), .rst(rst), .wr_en(cm_en), .wr_addr(cm_addr), .wr_be(cm_be),
        .wr_data(cm_data), .rd_addr(acc_addr), .rd_data(arr_data)
    );

    // R3 R11: registered read data and its enable
    always_ff @(posedge clk) begin
        if (rst) begin
            dq_oe  <= 1'b0;
            dq_out <= '0;
        end else begin
            dq_oe <= (acc_op == OP_READ);
            if (acc_op == OP_READ) dq_out <= rd_merged;
        end
    end

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int NCE    = DEF_NCE
) (
    input logic              clk,
    input logic              rst,
    input logic              adv,
    input logic [NCE-1:0]    bank_ce,
    input logic [NCE-1:0]    bank_pol,
    input logic [1:0]        acc_op,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              burst_live,
    input logic              dq_oe,
    input logic [1:0]        buf_fill
);

    p_read_drives_r3: assert property (@(posedge clk) disable iff (rst)
        (acc_op == OP_READ) |=> dq_oe);

    p_quiet_otherwise_r11: assert property (@(posedge clk) disable iff (rst)
        (acc_op != OP_READ) |=> !dq_oe);

    p_drain_r7: assert property (@(posedge clk) disable iff (rst)
        (acc_op != OP_WRITE && buf_fill != 2'd0) |=> (buf_fill == $past(buf_fill) - 2'd1));

    p_full_swap_r7: assert property (@(posedge clk) disable iff (rst)
        (acc_op == OP_WRITE && buf_fill == 2'd2) |=> (buf_fill == 2'd2));

    p_stray_adv_r9: assert property (@(posedge clk) disable iff (rst)
        (adv && !burst_live) |=> (acc_op == OP_IDLE));

    p_bank_miss_r10: assert property (@(posedge clk) disable iff (rst)
        (!adv && bank_ce != bank_pol) |=> (acc_op == OP_IDLE));

    p_burst_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (adv && burst_live) |=>
            (acc_op != OP_IDLE) &&
            (acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2])) &&
            (acc_addr[1:0] == $past(acc_addr[1:0]) + 2'd1));

endmodule

bind lw_sram lw_sram_chk #(.ADDR_W(ADDR_W), .NCE(NCE)) u_chk (
    .clk(clk), .rst(rst), .adv(adv), .bank_ce(bank_ce), .bank_pol(bank_pol),
    .acc_op(acc_op), .acc_addr(acc_addr), .burst_live(burst_live),
    .dq_oe(dq_oe), .buf_fill(buf_fill)
);

// File: tb/lw_sram_bench.sv
`timescale 1ns/1ps
module lw_sram_bench;

    localparam int AW = 6;
    localparam int DW = 36;
    localparam int NB = 4;
    localparam logic [1:0] CE = 2'b01;

    typedef struct packed {
        logic          cs;
        logic          we;
        logic          adv;
        logic [1:0]    blen;
        logic [1:0]    ce;
        logic [AW-1:0] addr;
        logic [NB-1:0] bwe;
        logic [DW-1:0] din;
    } row_t;

    function automatic row_t mk(input logic c, input logic w, input logic a,
                                input logic [1:0] bl, input logic [1:0] e,
                                input logic [AW-1:0] ad, input logic [NB-1:0] be,
                                input logic [DW-1:0] d);
        return '{cs: c, we: w, adv: a, blen: bl, ce: e, addr: ad, bwe: be, din: d};
    endfunction

    // a row's bwe/din belong to the write command of the row before it
    localparam int NROWS = 49;
    localparam row_t ROWS [NROWS] = '{
        mk(1,1,0,0,CE,6'h05,4'h0,36'h0),            // 0  R2 write 05
        mk(0,0,0,0,CE,6'h00,4'hF,36'h1_1111_1111),  // 1  R4 data
        mk(1,0,0,0,CE,6'h05,4'h0,36'h0),            // 2  R3 read 05
        mk(0,0,0,0,CE,6'h00,4'h0,36'h0),            // 3
        mk(1,1,0,0,CE,6'h08,4'h0,36'h0),            // 4  R7 three writes back to back
        mk(1,1,0,0,CE,6'h09,4'hF,36'hA_AAAA_AAAA),  // 5
        mk(1,1,0,0,CE,6'h08,4'hF,36'hB_BBBB_BBBB),  // 6
        mk(1,0,0,0,CE,6'h08,4'h3,36'hC_CCCC_CCCC),  // 7  R5 R6 partial, buffered
        mk(1,0,0,0,CE,6'h09,4'h0,36'h0),            // 8
        mk(0,0,0,0,CE,6'h00,4'h0,36'h0),            // 9
        mk(1,1,0,3,CE,6'h12,4'h0,36'h0),            // 10 R8 4-beat write burst
        mk(0,0,1,0,CE,6'h00,4'hF,36'h0_1010_1010),  // 11
        mk(0,0,1,0,CE,6'h00,4'hF,36'h0_2020_2020),  // 12
        mk(0,0,1,0,CE,6'h00,4'hF,36'h0_3030_3030),  // 13
        mk(0,0,0,0,CE,6'h00,4'hF,36'h0_4040_4040),  // 14
        mk(1,0,0,3,CE,6'h13,4'h0,36'h0),            // 15 R8 4-beat read burst
        mk(0,0,1,0,CE,6'h00,4'h0,36'h0),            // 16
        mk(0,0,1,0,CE,6'h00,4'h0,36'h0),            // 17
        mk(0,0,1,0,CE,6'h00,4'h0,36'h0),            // 18
        mk(0,0,1,0,CE,6'h00,4'h0,36'h0),            // 19 R9 past last beat
        mk(0,0,0,0,CE,6'h00,4'h0,36'h0),            // 20
        mk(0,0,1,0,CE,6'h00,4'h0,36'h0),            // 21 R9 no burst
        mk(0,0,0,0,CE,6'h00,4'h0,36'h0),            // 22
        mk(1,0,0,1,CE,6'h10,4'h0,36'h0),            // 23 R8 2-beat read
        mk(0,0,1,0,CE,6'h00,4'h0,36'h0),            // 24
        mk(0,0,1,0,CE,6'h00,4'h0,36'h0),            // 25 R9
        mk(0,0,0,0,CE,6'h00,4'h0,36'h0),            // 26
        mk(1,1,0,0,2'b10,6'h05,4'h0,36'h0),         // 27 R10 bank miss
        mk(0,0,0,0,CE,6'h00,4'hF,36'hF_FFFF_FFFF),  // 28
        mk(1,0,0,0,CE,6'h05,4'h0,36'h0),            // 29
        mk(0,0,0,0,CE,6'h00,4'h0,36'h0),            // 30
        mk(0,1,0,0,CE,6'h05,4'h0,36'h0),            // 31 R10 cs low
        mk(0,0,0,0,CE,6'h00,4'hF,36'h9_9999_9999),  // 32
        mk(1,0,0,0,CE,6'h05,4'h0,36'h0),            // 33
        mk(0,0,0,0,CE,6'h00,4'h0,36'h0),            // 34
        mk(1,0,0,3,CE,6'h20,4'h0,36'h0),            // 35 R12 burst then new command
        mk(1,0,0,0,CE,6'h09,4'h0,36'h0),            // 36
        mk(0,0,1,0,CE,6'h00,4'h0,36'h0),            // 37
        mk(0,0,0,0,CE,6'h00,4'h0,36'h0),            // 38
        mk(1,1,0,0,CE,6'h2A,4'h0,36'h0),            // 39 R6 read as data lands
        mk(1,0,0,0,CE,6'h2A,4'hF,36'hE_0E0E_0E0E),  // 40
        mk(0,0,0,0,CE,6'h00,4'h0,36'h0),            // 41
        mk(1,1,0,2,CE,6'h33,4'h0,36'h0),            // 42 R8 3-beat write wrap
        mk(0,0,1,0,CE,6'h00,4'hF,36'h5_0000_0005),  // 43
        mk(0,0,1,0,CE,6'h00,4'h5,36'h6_0000_0006),  // 44 R5 lanes 0,2
        mk(1,0,0,1,CE,6'h30,4'hF,36'h7_0000_0007),  // 45
        mk(0,0,1,0,CE,6'h00,4'h0,36'h0),            // 46
        mk(0,0,0,0,CE,6'h00,4'h0,36'h0),            // 47
        mk(0,0,0,0,CE,6'h00,4'h0,36'h0)             // 48
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          cs, we, adv;
    logic [1:0]    blen, bank_ce, bank_pol;
    logic [AW-1:0] addr;
    logic [NB-1:0] bwe;
    logic [DW-1:0] dq_in, dq_out;
    logic          dq_oe;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    lw_sram u_lw_sram (
        .clk(clk), .rst(rst), .cs(cs), .we(we), .adv(adv), .blen(blen),
        .addr(addr), .bank_ce(bank_ce), .bank_pol(bank_pol), .bwe(bwe),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // reference model
    logic [DW-1:0] ref_mem [1<<AW];
    int            p_op;
    logic [AW-1:0] p_addr, b_addr;
    int            b_left;
    logic          b_wr;
    logic          exp_oe;
    logic [DW-1:0] exp_dq;

    task automatic model_reset();
        for (int i = 0; i < (1<<AW); i++) ref_mem[i] = '0;
        p_op = 0; p_addr = '0; b_addr = '0; b_left = 0; b_wr = 1'b0;
    endtask

    task automatic model_edge(input row_t r);
        exp_oe = (p_op == 1);
        if (exp_oe) exp_dq = ref_mem[p_addr];
        if (p_op == 2)
            for (int b = 0; b < NB; b++)
                if (r.bwe[b]) ref_mem[p_addr][b*9 +: 9] = r.din[b*9 +: 9];
        if (r.adv) begin
            if (b_left > 0) begin
                p_op   = b_wr ? 2 : 1;
                p_addr = {b_addr[AW-1:2], b_addr[1:0] + 2'd1};
                b_addr = p_addr;
                b_left = b_left - 1;
            end else begin
                p_op = 0; b_left = 0;
            end
        end else if (r.cs && r.ce == bank_pol) begin
            p_op   = r.we ? 2 : 1;
            p_addr = r.addr; b_addr = r.addr;
            b_left = int'(r.blen); b_wr = r.we;
        end else begin
            p_op = 0; b_left = 0;
        end
    endtask

    // entered and left at a falling edge
    task automatic run_row(input row_t r, input int idx);
        cs = r.cs; we = r.we; adv = r.adv; blen = r.blen; bank_ce = r.ce;
        addr = r.addr; bwe = r.bwe; dq_in = r.din;
        @(posedge clk);
        model_edge(r);
        @(negedge clk);
        checks++;
        if (dq_oe !== exp_oe) begin
            errors++;
            $display("FAIL R3/R9/R10/R11 row %0d dq_oe=%b expected %b", idx, dq_oe, exp_oe);
        end
        if (exp_oe) begin
            checks++;
            if (dq_out !== exp_dq) begin
                errors++;
                $display("FAIL R5/R6/R8 row %0d dq_out=%h expected %h", idx, dq_out, exp_dq);
            end
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; cs = 0; we = 0; adv = 0; blen = 0; bank_ce = CE;
        bank_pol = CE; addr = '0; bwe = '0; dq_in = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        checks++;
        if (dq_oe !== 1'b0 || dq_out !== '0) begin
            errors++;
            $display("FAIL R1 after reset dq_oe=%b dq_out=%h expected 0 0", dq_oe, dq_out);
        end

        foreach (ROWS[i]) run_row(ROWS[i], i);

        // R10 reprogrammed polarity: only the new pattern responds
        bank_pol = 2'b10;
        run_row(mk(1,1,0,0,2'b10,6'h03,4'h0,36'h0), 100);
        run_row(mk(0,0,0,0,2'b10,6'h00,4'hF,36'h3_3333_3333), 101);
        run_row(mk(1,0,0,0,2'b10,6'h03,4'h0,36'h0), 102);
        run_row(mk(1,0,0,0,CE,6'h05,4'h0,36'h0), 103);
        run_row(mk(0,0,0,0,CE,6'h00,4'h0,36'h0), 104);
        bank_pol = CE;

        // R1 reset in mid-run clears stored words
        run_row(mk(1,1,0,0,CE,6'h07,4'h0,36'h0), 110);
        run_row(mk(0,0,0,0,CE,6'h00,4'hF,36'h7_7777_7777), 111);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        checks++;
        if (dq_oe !== 1'b0) begin
            errors++;
            $display("FAIL R1 mid-run reset dq_oe=%b expected 0", dq_oe);
        end
        run_row(mk(1,0,0,0,CE,6'h07,4'h0,36'h0), 112);
        run_row(mk(1,0,0,0,CE,6'h05,4'h0,36'h0), 113);
        run_row(mk(0,0,0,0,CE,6'h00,4'h0,36'h0), 114);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule